// File: doc/BRIEF.md
# Gated Dual-Ratio Clock Divider

This block derives two slower clocks from one input clock. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter, one fifth or one sixth of it. Both outputs come from a single synchronous counter structure. A frame counter spans the least common multiple of the two ratios and returns both phase counters to zero at every frame boundary. Every edge that the two outputs share therefore falls on the same input-clock edge. If the block starts from an unknown state, the two outputs fall into alignment by themselves within one frame.

An active-low run input is captured on the falling edge of the input clock. A small gating state machine acts on it at the following rising edge. Stopping never cuts a high pulse short. While disabled, the dividers keep counting until both outputs are low (GS_DRAIN), and then they freeze (GS_HALT). Setting the run input again moves the machine back to GS_RUN, and counting resumes from the frozen phase. The named transitions are:
- GS_HALT to GS_RUN when enabled.
- GS_RUN to GS_DRAIN when disabled while a pulse is high.
- GS_RUN or GS_DRAIN to GS_HALT when disabled and both outputs are low.
- GS_DRAIN to GS_RUN when re-enabled.

A master reset clears every stage at once without waiting for a clock edge, and its release is synchronised to the input clock. Several copies released from the same reset therefore start in the same phase. The select inputs are static and are changed only while reset is held.

Top module: `multi_ratio_clkdiv`

## Requirements
- R1: With sel_a=0, out_a repeats high 1 cycle, low 1 cycle (divide by 2). With sel_a=1, it repeats high 2, low 2 (divide by 4). Cycles count rising edges of clk_in on which the dividers advance.
- R2: sel_b selects out_b as follows: sel_b=00 gives high 2, low 2 (divide by 4); sel_b=01 gives high 2, low 3 (divide by 5); sel_b=10 or 11 gives high 3, low 3 (divide by 6).
- R3: After reset, the first advance raises both outputs together. Coincident rising edges of out_a and out_b occur exactly on the advances numbered 1 + n·L, where L is the least common multiple of the two ratios. Each frame boundary also clears both phase counters.
- R4: run_n is active low and is sampled on the falling edge of clk_in. A change made just after a falling edge has no effect at the next rising edge and takes effect at the one after it.
- R5: While run_n is high, no high pulse on either output is shortened. The dividers keep advancing until both outputs are low, then freeze, and both outputs stay low for as long as run_n stays high.
- R6: When run_n goes low again, counting continues from the frozen phase, not from phase zero.
- R7: Asserting mrst drives both outputs low at once, without any clock edge, and holds them low while it stays asserted.
- R8: Reset release is synchronised. Both outputs stay low at the first two rising edges after mrst falls. With run_n already low, both outputs rise at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; all divider stages advance on its rising edge |
| mrst | input | 1 | Master reset, active high, asynchronous assert |
| run_n | input | 1 | Active-low enable, captured on the falling edge of clk_in |
| sel_a | input | 1 | Ratio select for out_a (0: /2, 1: /4) |
| sel_b | input | 2 | Ratio select for out_b (00: /4, 01: /5, 1x: /6) |
| out_a | output | 1 | Divided clock A |
| out_b | output | 1 | Divided clock B |

## Verification
A phase counter that skips or repeats a state shows up within one output period as a high or low run of the wrong length on that output. A frame counter with the wrong limit breaks the coincident-rise pattern at the next frame boundary, which is at most 20 advances later. A gating state machine that freezes too early cuts a pulse short at the moment of disable, and one that resumes wrongly shows a phase jump on the first advance after re-enable. The bench compares both outputs on every cycle against phases it computes from the advance count, across all select combinations and several enable patterns.

// File: rtl/mrd_pkg.sv
`timescale 1ns/1ps
package mrd_pkg;

    typedef enum logic [1:0] {
        GS_HALT  = 2'd0,
        GS_RUN   = 2'd1,
        GS_DRAIN = 2'd2
    } gate_state_e;

    function automatic int a_ratio(input logic sa);
        return sa ? 4 : 2;
    endfunction

    function automatic int a_high(input logic sa);
        return sa ? 2 : 1;
    endfunction

    function automatic int b_ratio(input logic [1:0] sb);
        case (sb)
            2'b00:   return 4;
            2'b01:   return 5;
            default: return 6;
        endcase
    endfunction

    function automatic int b_high(input logic [1:0] sb);
        case (sb)
            2'b00:   return 2;
            2'b01:   return 2;
            default: return 3;
        endcase
    endfunction

    // least common multiple of the two selected ratios
    function automatic int frame_len(input logic sa, input logic [1:0] sb);
        int ra;
        int rb;
        int m;
        ra = a_ratio(sa);
        rb = b_ratio(sb);
        m  = ra * rb;
        for (int i = 4; i >= 1; i--) begin
            if (((i * rb) % ra) == 0) m = i * rb;
        end
        return m;
    endfunction

endpackage

// File: rtl/mrd_reset_sync.sv
`timescale 1ns/1ps
module mrd_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic mrst,
    output logic rst_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) chain <= '0;
        else      chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_o = ~chain[STAGES-1];
endmodule

// File: rtl/mrd_enable_gate.sv
`timescale 1ns/1ps
module mrd_enable_gate
    import mrd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_n,
    input  logic busy,
    output logic en_q,
    output logic advance
);
    gate_state_e state, state_nx;

    // enable captured while the input clock is low
    always_ff @(negedge clk or posedge rst) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ~run_n;
    end

    always_comb begin
        state_nx = GS_HALT;
        unique case (state)
            GS_HALT:  state_nx = en_q ? GS_RUN : GS_HALT;
            GS_RUN:   state_nx = en_q ? GS_RUN : (busy ? GS_DRAIN : GS_HALT);
            GS_DRAIN: state_nx = en_q ? GS_RUN : (busy ? GS_DRAIN : GS_HALT);
            default:  state_nx = GS_HALT;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= GS_HALT;
        else     state <= state_nx;
    end

    always_comb begin
        advance = (state_nx != GS_HALT);
    end
endmodule

// File: rtl/mrd_phase_div.sv
`timescale 1ns/1ps
module mrd_phase_div #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic         restart,
    input  logic [W-1:0] ratio,
    input  logic [W-1:0] high,
    output logic         div_o
);
    logic [W-1:0] phase;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            phase <= '0;
            div_o <= 1'b0;
        end else if (advance) begin
            div_o <= (phase < high);
            if (restart || (phase >= ratio - W'(1))) phase <= '0;
            else                                      phase <= phase + W'(1);
        end
    end
endmodule

// File: rtl/multi_ratio_clkdiv.sv
`timescale 1ns/1ps
module multi_ratio_clkdiv
    import mrd_pkg::*;
#(
    parameter int PHASE_W     = 3,
    parameter int FRAME_W     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_in,
    input  logic       mrst,
    input  logic       run_n,
    input  logic       sel_a,
    input  logic [1:0] sel_b,
    output logic       out_a,
    output logic       out_b
);
    logic               rst_int;
    logic               en_q;
    logic               advance;
    logic               frame_end;
    logic [FRAME_W-1:0] frame_ph;
    logic [FRAME_W-1:0] frame_lim;
    logic [PHASE_W-1:0] ratio_a, high_a, ratio_b, high_b;

    assign ratio_a   = PHASE_W'(a_ratio(sel_a));
    assign high_a    = PHASE_W'(a_high(sel_a));
    assign ratio_b   = PHASE_W'(b_ratio(sel_b));
    assign high_b    = PHASE_W'(b_high(sel_b));
    assign frame_lim = FRAME_W'(frame_len(sel_a, sel_b));
    assign frame_end = (frame_ph >= frame_lim - FRAME_W'(1));

    mrd_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
        .clk   (clk_in),
        .mrst  (mrst),
        .rst_o (rst_int)
    );

    mrd_enable_gate u_gate (
        .clk     (clk_in),
        .rst     (rst_int),
        .run_n   (run_n),
        .busy    (out_a | out_b),
        .en_q    (en_q),
        .advance (advance)
    );

    // frame counter spanning the common multiple of both ratios
    always_ff @(posedge clk_in or posedge rst_int) begin
        if (rst_int)      frame_ph <= '0;
        else if (advance) frame_ph <= frame_end ? '0 : frame_ph + FRAME_W'(1);
    end

    mrd_phase_div #(.W(PHASE_W)) u_div_a (
        .clk     (clk_in),
        .rst     (rst_int),
        .advance (advance),
        .restart (frame_end),
        .ratio   (ratio_a),
        .high    (high_a),
        .div_o   (out_a)
    );

    mrd_phase_div #(.W(PHASE_W)) u_div_b (
        .clk     (clk_in),
        .rst     (rst_int),
        .advance (advance),
        .restart (frame_end),
        .ratio   (ratio_b),
        .high    (high_b),
        .div_o   (out_b)
    );
endmodule

// File: rtl/mrd_checker.sv
`timescale 1ns/1ps
module mrd_checker #(
    parameter int FRAME_W = 5
) (
    input logic               clk,
    input logic               rst_int,
    input logic               en_q,
    input logic               sel_a,
    input logic [1:0]         sel_b,
    input logic               out_a,
    input logic               out_b,
    input logic [FRAME_W-1:0] frame_ph
);
    AST_A_HALF_PULSE: assert property (@(posedge clk) disable iff (rst_int)
        ($rose(out_a) && !sel_a) |=> !out_a); // R1

    AST_A_QUARTER_PULSE: assert property (@(posedge clk) disable iff (rst_int)
        ($rose(out_a) && sel_a) |=> out_a); // R1

    AST_B_MIN_HIGH: assert property (@(posedge clk) disable iff (rst_int)
        $rose(out_b) |=> out_b); // R2

    AST_B_SIX_HIGH: assert property (@(posedge clk) disable iff (rst_int)
        ($rose(out_b) && sel_b[1]) |=> out_b ##1 out_b); // R2

    AST_FRAME_COMMON_RISE: assert property (@(posedge clk) disable iff (rst_int)
        ($rose(out_a) && (frame_ph == FRAME_W'(1))) |-> $rose(out_b)); // R3

    AST_HOLD_LOW_DISABLED: assert property (@(posedge clk) disable iff (rst_int)
        (!en_q && !out_a && !out_b) |=> (!out_a && !out_b)); // R5

    AST_RESET_LOW: assert property (@(posedge clk)
        rst_int |-> (!out_a && !out_b)); // R7
endmodule

bind multi_ratio_clkdiv mrd_checker #(.FRAME_W(FRAME_W)) u_chk (
    .clk      (clk_in),
    .rst_int  (rst_int),
    .en_q     (en_q),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .out_a    (out_a),
    .out_b    (out_b),
    .frame_ph (frame_ph)
);

// File: tb/multi_ratio_clkdiv_bench.sv
`timescale 1ns/1ps
module multi_ratio_clkdiv_bench;
    logic       clk = 1'b0;
    logic       mrst = 1'b1;
    logic       run_n = 1'b1;
    logic       sel_a = 1'b0;
    logic [1:0] sel_b = 2'b00;
    logic       out_a, out_b;

    int n_chk = 0;
    int n_fail = 0;
    int k, ra, rb, coin;
    int na, ha, nb, hb, mm;
    logic ea, eb, pa, pb;

    always #10 clk = ~clk;

    multi_ratio_clkdiv u_multi_ratio_clkdiv (
        .clk_in (clk),
        .mrst   (mrst),
        .run_n  (run_n),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .out_a  (out_a),
        .out_b  (out_b)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int gcd(input int x, input int y);
        int p;
        int q;
        int t;
        p = x;
        q = y;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    task automatic set_cfg();
        na = sel_a ? 4 : 2;
        ha = na / 2;
        case (sel_b)
            2'b00:   begin nb = 4; hb = 2; end
            2'b01:   begin nb = 5; hb = 2; end
            default: begin nb = 6; hb = 3; end
        endcase
        mm = (na * nb) / gcd(na, nb);
    endtask

    function automatic logic f_out(input int kk, input int n, input int h);
        if (kk == 0) return 1'b0;
        return (((kk - 1) % n) < h);
    endfunction

    task automatic clear_model();
        k = 0; ea = 0; eb = 0; pa = 0; pb = 0; ra = 0; rb = 0; coin = 0;
    endtask

    task automatic do_reset();
        mrst = 1'b1;
        run_n = 1'b1;
        repeat (2) @(posedge clk);
        #2 mrst = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        clear_model();
        check(!out_a && !out_b, "R8 reset state", {out_a, out_b}, 0);
    endtask

    task automatic step(input bit en, input string ta, input string tb);
        run_n = ~en;
        @(posedge clk);
        if (en || ea || eb) k++;
        ea = f_out(k, na, ha);
        eb = f_out(k, nb, hb);
        #2;
        check(out_a === ea, ta, out_a, ea);
        check(out_b === eb, tb, out_b, eb);
        if (out_a) ra++;
        else begin
            if (ra != 0) check(ra == ha, "R5 out_a pulse length", ra, ha);
            ra = 0;
        end
        if (out_b) rb++;
        else begin
            if (rb != 0) check(rb == hb, "R5 out_b pulse length", rb, hb);
            rb = 0;
        end
        if (out_a && !pa && out_b && !pb) begin
            coin++;
            check(((k - 1) % mm) == 0, "R3 common rise on frame", (k - 1) % mm, 0);
        end
        pa = out_a;
        pb = out_b;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int kb;
        // sweep every select combination
        for (int sa = 0; sa < 2; sa++) begin
            for (int sb = 0; sb < 4; sb++) begin
                sel_a = sa[0];
                sel_b = sb[1:0];
                set_cfg();
                do_reset();
                for (int i = 0; i < 3 * mm; i++) step(1'b1, "R1", "R2");
                check(coin == 3, "R3 coincident rises", coin, 3);
                for (int i = 0; i < 4 * mm; i++)
                    step(((i * 7) % 11) >= 4, "R5 toggled", "R5 toggled");
                for (int i = 0; i < 12; i++) step(1'b0, "R5 held low", "R5 held low");
                kb = k;
                step(1'b1, "R6 resume", "R6 resume");
                check(k == kb + 1, "R6 phase continues", k, kb + 1);
                for (int i = 0; i < 2 * mm; i++) step(1'b1, "R6", "R6");
            end
        end

        // falling-edge capture of run_n (R4)
        sel_a = 1'b0;
        sel_b = 2'b00;
        set_cfg();
        do_reset();
        @(negedge clk);
        #2 run_n = 1'b0;
        @(posedge clk);
        #2 check(!out_a && !out_b, "R4 no effect before falling edge", {out_a, out_b}, 0);
        @(posedge clk);
        #2 check(out_a && out_b, "R4 effect after falling edge", {out_a, out_b}, 3);
        k = 1; ea = 1; eb = 1; pa = 1; pb = 1; ra = 1; rb = 1;
        for (int i = 0; i < 8; i++) step(1'b1, "R4 R1", "R4 R2");

        // asynchronous assert, synchronous release (R7, R8)
        sel_a = 1'b1;
        sel_b = 2'b11;
        set_cfg();
        do_reset();
        step(1'b1, "R1", "R2");
        mrst = 1'b1;
        #1 check(!out_a && !out_b, "R7 async clear", {out_a, out_b}, 0);
        run_n = 1'b0;
        @(posedge clk);
        #2 check(!out_a && !out_b, "R7 held in reset", {out_a, out_b}, 0);
        mrst = 1'b0;
        @(posedge clk);
        #2 check(!out_a && !out_b, "R8 first edge after release", {out_a, out_b}, 0);
        @(posedge clk);
        #2 check(!out_a && !out_b, "R8 second edge after release", {out_a, out_b}, 0);
        @(posedge clk);
        #2 check(out_a && out_b, "R8 third edge after release", {out_a, out_b}, 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule